// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of scatter-gather segments into a table of physical-region descriptors for a bus-mastering disk controller. Each segment (a 32-bit bus address and a 32-bit byte length) arrives on a valid/ready handshake, with a flag on the final segment of a list. The block cuts every segment into chunks that never straddle a 64 KiB address boundary. For each chunk it writes a two-word entry into the table memory through a plain write port (word index, data, write enable). When the list is complete it raises a one-cycle completion pulse with the number of entries built, or a failure flag. The failure flag tells the host to move the request by programmed I/O instead.

Two static settings are latched when the first segment of a list is accepted. The split setting is for controllers that read a zero length field as zero bytes rather than 64 KiB. With it set, a full 64 KiB chunk is written as two 32 KiB entries. The alternate setting moves the length into the upper half of the count word as a count of 32-bit words minus one. In that encoding no end-of-table bit is written.

Top module: `prd_splitter`

## Requirements
- R1: Entry k occupies table words 2k (bus address) and 2k+1 (count word). In the normal encoding, count-word bits 15:0 hold the chunk length, with 0x0000 meaning 64 KiB, and bits 30:16 are zero. A successful build writes no word at index 2n or above, where n is the entry count.
- R2: Each chunk length is the minimum of the remaining segment length and 0x10000 minus address bits 15:0. Entries follow segment order and address order, each starting where the previous chunk ended.
- R3: With split set and the normal encoding, a chunk of exactly 64 KiB at address a becomes two entries: (a, 0x8000) and (a+0x8000, 0x8000).
- R4: In the normal encoding, bit 31 of the count word of the final entry is set, and it is clear in every other entry.
- R5: With alternate set, the count word is {((len[15:0] >> 2) - 1) mod 2^16, 16'h0000}. No end bit is added, and split has no effect.
- R6: If an entry would be needed beyond MAX_ENTRIES (a split's second half included), the build fails. The completion pulse then reports fail=1 and count=0. Remaining segments up to the last one are still accepted and discarded, and the following list builds normally.
- R7: Zero-length segments produce no entries. A list that yields no entries completes with fail=1 and count=0.
- R8: The completion pulse lasts exactly one cycle per list and follows the acceptance of the last segment. seg_ready is low while entries are being written.
- R9: split_en and alt_len are sampled when the first segment of a list is accepted. Changes later in the same list have no effect.
- R10: After reset, seg_ready is high and done and wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_en | input | 1 | Split full 64 KiB chunks into two halves |
| alt_len | input | 1 | Use the word-count length encoding |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | 32 | Segment byte length |
| seg_last | input | 1 | Final segment of the list |
| wr_en | output | 1 | Table write strobe |
| wr_idx | output | $clog2(2*MAX_ENTRIES) | Table word index |
| wr_data | output | 32 | Table word |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | $clog2(MAX_ENTRIES+1) | Entries built (0 on failure) |
| done_fail | output | 1 | Build failed; use programmed I/O |

## Verification
Directed lists cover each case that produces a different table. These are a chunk inside one 64 KiB window, a chunk crossing a window edge, and an aligned full 64 KiB chunk in both split settings. An offset 64 KiB segment shows that only exact window-sized chunks are halved. A list ending in a zero-length segment shows that the end bit lands on the preceding entry. Lists of exactly 256 entries and one entry more, in both split settings, separate success from overflow at the capacity edge. A failed list followed by a clean one shows the drain and recovery. Randomly sized and placed multi-segment lists in all four mode combinations, some with settings changed mid-list, compare every written word against a bench model.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam logic [16:0] WIN     = 17'h10000;
  localparam logic [16:0] HALFWIN = 17'h08000;
  localparam int unsigned END_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CNT,
    ST_FIN
  } build_st_e;
endpackage

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc
  import prd_pkg::*;
(
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [WORD_W-1:0] remain,
  input  logic              halve_full,
  output logic [16:0]       chunk
);
  logic [16:0] to_edge;
  logic [16:0] raw;

  always_comb begin
    to_edge = WIN - {1'b0, cur_addr[15:0]};
    if (remain < {15'b0, to_edge}) raw = remain[16:0];
    else                           raw = to_edge;
    if (halve_full && raw == WIN) chunk = HALFWIN;
    else                          chunk = raw;
  end
endmodule

// File: rtl/prd_word_fmt.sv
module prd_word_fmt
  import prd_pkg::*;
(
  input  logic [16:0]       chunk,
  input  logic              word_mode,
  output logic [WORD_W-1:0] cnt_word
);
  logic [15:0] words_m1;

  always_comb begin
    words_m1 = {2'b00, chunk[15:2]} - 16'd1;
    if (word_mode) cnt_word = {words_m1, 16'h0000};
    else           cnt_word = {16'h0000, chunk[15:0]};
  end
endmodule

// File: rtl/prd_splitter.sv
module prd_splitter
  import prd_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 256,
  localparam int unsigned IDXW = $clog2(2*MAX_ENTRIES),
  localparam int unsigned CNTW = $clog2(MAX_ENTRIES+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_en,
  input  logic              alt_len,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [31:0]       seg_addr,
  input  logic [31:0]       seg_len,
  input  logic              seg_last,
  output logic              wr_en,
  output logic [IDXW-1:0]   wr_idx,
  output logic [31:0]       wr_data,
  output logic              done,
  output logic [CNTW-1:0]   done_count,
  output logic              done_fail
);
  localparam logic [CNTW-1:0] CAP = CNTW'(MAX_ENTRIES);

  build_st_e          state_q, state_d;
  logic [WORD_W-1:0]  addr_q, addr_d, rem_q, rem_d, lastcw_q, lastcw_d;
  logic [CNTW-1:0]    count_q, count_d;
  logic               last_q, last_d, fail_q, fail_d;
  logic               split_q, split_d, alt_q, alt_d, busy_q, busy_d;
  logic [16:0]        chunk;
  logic [WORD_W-1:0]  cnt_word;
  logic               take;

  prd_chunk_calc u_chunk (
    .cur_addr   (addr_q),
    .remain     (rem_q),
    .halve_full (split_q & ~alt_q),
    .chunk      (chunk)
  );

  prd_word_fmt u_fmt (
    .chunk     (chunk),
    .word_mode (alt_q),
    .cnt_word  (cnt_word)
  );

  assign seg_ready  = (state_q == ST_IDLE);
  assign take       = seg_ready & seg_valid;
  assign done       = (state_q == ST_FIN);
  assign done_fail  = fail_q | (count_q == '0);
  assign done_count = done_fail ? '0 : count_q;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    lastcw_d = lastcw_q;
    count_d  = count_q;
    last_d   = last_q;
    fail_d   = fail_q;
    split_d  = split_q;
    alt_d    = alt_q;
    busy_d   = busy_q;
    wr_en    = 1'b0;
    wr_idx   = '0;
    wr_data  = '0;
    unique case (state_q)
      ST_IDLE: if (take) begin
        if (!busy_q) begin
          split_d = split_en;
          alt_d   = alt_len;
        end
        busy_d = 1'b1;
        addr_d = seg_addr;
        rem_d  = seg_len;
        last_d = seg_last;
        if (fail_q || seg_len == '0) state_d = seg_last ? ST_FIN : ST_IDLE;
        else                         state_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (count_q == CAP) begin
          fail_d  = 1'b1;
          state_d = last_q ? ST_FIN : ST_IDLE;
        end else begin
          wr_en   = 1'b1;
          wr_idx  = IDXW'({count_q, 1'b0});
          wr_data = addr_q;
          state_d = ST_CNT;
        end
      end
      ST_CNT: begin
        wr_en    = 1'b1;
        wr_idx   = IDXW'({count_q, 1'b1});
        wr_data  = cnt_word;
        lastcw_d = cnt_word;
        count_d  = count_q + CNTW'(1);
        addr_d   = addr_q + WORD_W'(chunk);
        rem_d    = rem_q - WORD_W'(chunk);
        if (rem_d == '0) state_d = last_q ? ST_FIN : ST_IDLE;
        else             state_d = ST_ADDR;
      end
      ST_FIN: begin
        if (!fail_q && count_q != '0 && !alt_q) begin
          wr_en   = 1'b1;
          wr_idx  = IDXW'({count_q - CNTW'(1), 1'b1});
          wr_data = lastcw_q | (WORD_W'(1) << END_BIT);
        end
        count_d = '0;
        fail_d  = 1'b0;
        busy_d  = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      lastcw_q <= '0;
      count_q  <= '0;
      last_q   <= 1'b0;
      fail_q   <= 1'b0;
      split_q  <= 1'b0;
      alt_q    <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      rem_q    <= rem_d;
      lastcw_q <= lastcw_d;
      count_q  <= count_d;
      last_q   <= last_d;
      fail_q   <= fail_d;
      split_q  <= split_d;
      alt_q    <= alt_d;
      busy_q   <= busy_d;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !seg_ready);

  // R2
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CNT) |-> (({2'b00, addr_q[15:0]} + {1'b0, chunk}) <= 18'h10000 && chunk != '0));

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < 2*MAX_ENTRIES));

  // R6
  no_write_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> !wr_en);
endmodule

// File: tb/sim_prd_splitter.sv
module sim_prd_splitter;
  localparam int MAXE = 256;
  localparam int IDXW = $clog2(2*MAXE);
  localparam int CNTW = $clog2(MAXE+1);

  logic clk = 1'b0;
  logic rst_n;
  logic split_en, alt_len, seg_valid, seg_ready, seg_last;
  logic [31:0] seg_addr, seg_len;
  logic wr_en, done, done_fail;
  logic [IDXW-1:0] wr_idx;
  logic [31:0] wr_data;
  logic [CNTW-1:0] done_count;

  always #10 clk = ~clk;

  prd_splitter #(.MAX_ENTRIES(MAXE)) u0 (
    .clk(clk), .rst_n(rst_n), .split_en(split_en), .alt_len(alt_len),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .done(done), .done_count(done_count), .done_fail(done_fail)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [31:0] mem [0:2*MAXE-1];
  int done_seen;
  int cap_cnt;
  bit cap_fail;

  logic [31:0] seg_a [0:15];
  logic [31:0] seg_l [0:15];
  int nseg;
  logic [31:0] exp_a [0:2*MAXE];
  logic [31:0] exp_c [0:2*MAXE];
  int exp_n;
  bit exp_fail;

  always @(negedge clk) begin
    cycles++;
    if (wr_en) mem[wr_idx] = wr_data;
    if (done) begin
      done_seen++;
      cap_cnt  = int'(done_count);
      cap_fail = done_fail;
    end
  end

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input bit sp, input bit al);
    logic [31:0] a, r, b;
    exp_n = 0;
    exp_fail = 0;
    for (int i = 0; i < nseg; i++) begin
      a = seg_a[i];
      r = seg_l[i];
      while (r != 0 && !exp_fail) begin
        b = 32'h10000 - (a & 32'hFFFF);
        if (b > r) b = r;
        if (!al && sp && b == 32'h10000) b = 32'h8000;
        if (exp_n >= MAXE) exp_fail = 1;
        else begin
          exp_a[exp_n] = a;
          exp_c[exp_n] = al ? ((((b & 32'hFFFF) >> 2) - 32'd1) << 16) : (b & 32'hFFFF);
          exp_n++;
          a = a + b;
          r = r - b;
        end
      end
    end
    if (!exp_fail && exp_n > 0 && !al) exp_c[exp_n-1] = exp_c[exp_n-1] | 32'h8000_0000;
    if (exp_n == 0) exp_fail = 1;
  endtask

  task automatic run_build(input string req, input bit sp, input bit al, input bit flip);
    for (int k = 0; k < 2*MAXE; k++) mem[k] = 32'hDEAD_BEEF;
    model(sp, al);
    @(negedge clk);
    done_seen = 0;
    split_en = sp;
    alt_len  = al;
    for (int i = 0; i < nseg; i++) begin
      seg_valid = 1'b1;
      seg_addr  = seg_a[i];
      seg_len   = seg_l[i];
      seg_last  = (i == nseg-1);
      while (!seg_ready) @(negedge clk);
      @(negedge clk);
      if (flip && i == 0) begin
        split_en = !sp;
        alt_len  = !al;
      end
    end
    seg_valid = 1'b0;
    seg_last  = 1'b0;
    for (int w = 0; w < 3000 && done_seen == 0; w++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    // R8: exactly one completion pulse
    chk({req, "/R8 pulses"}, done_seen == 1, done_seen, 1);
    if (exp_fail) begin
      chk({req, "/fail flag"}, cap_fail == 1'b1, cap_fail, 1);
      chk({req, "/fail count"}, cap_cnt == 0, cap_cnt, 0);
    end else begin
      chk({req, "/fail flag"}, cap_fail == 1'b0, cap_fail, 0);
      chk({req, "/count"}, cap_cnt == exp_n, cap_cnt, exp_n);
      for (int k = 0; k < exp_n; k++) begin
        chk({req, "/addr word"}, mem[2*k] === exp_a[k], mem[2*k], exp_a[k]);
        chk({req, "/count word"}, mem[2*k+1] === exp_c[k], mem[2*k+1], exp_c[k]);
      end
      // R1: nothing past the table end
      if (2*exp_n < 2*MAXE)
        chk({req, "/R1 past end"}, mem[2*exp_n] === 32'hDEAD_BEEF, mem[2*exp_n], 32'hDEAD_BEEF);
    end
    split_en = 1'b0;
    alt_len  = 1'b0;
  endtask

  task automatic one(input logic [31:0] a, input logic [31:0] l);
    nseg = 1; seg_a[0] = a; seg_l[0] = l;
  endtask

  task automatic two(input logic [31:0] a0, input logic [31:0] l0, input logic [31:0] a1, input logic [31:0] l1);
    nseg = 2; seg_a[0] = a0; seg_l[0] = l0; seg_a[1] = a1; seg_l[1] = l1;
  endtask

  initial begin
    while (cycles < 190000) @(negedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    rst_n = 1'b0; split_en = 0; alt_len = 0; seg_valid = 0; seg_last = 0;
    seg_addr = '0; seg_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready", seg_ready == 1'b1, seg_ready, 1);
    chk("R10 done", done == 1'b0, done, 0);
    chk("R10 wr_en", wr_en == 1'b0, wr_en, 0);

    one(32'h1000_0010, 32'h200);       run_build("R1 single", 0, 0, 0);
    one(32'h2000_FF00, 32'h300);       run_build("R2 cross", 0, 0, 0);
    one(32'h2001_0000, 32'h2_4000);    run_build("R2 multi window", 0, 0, 0);
    one(32'h3000_0000, 32'h1_0000);    run_build("R1 full window", 0, 0, 0);
    one(32'h3000_0000, 32'h1_0000);    run_build("R3 split full", 1, 0, 0);
    one(32'h4000_8000, 32'h1_0000);    run_build("R3 split offset", 1, 0, 0);
    one(32'h5000_0000, 32'h100);       run_build("R5 alt", 0, 1, 0);
    one(32'h5000_0000, 32'h1_0000);    run_build("R5 alt no split", 1, 1, 0);
    two(32'h6000_0000, 32'h40, 32'h7000_0000, 32'h0); run_build("R4 trailing zero", 0, 0, 0);
    one(32'h6000_0000, 32'h0);         run_build("R7 empty", 0, 0, 0);
    two(32'h6000_0000, 32'h0, 32'h6100_0000, 32'h0); run_build("R7 empty two", 1, 0, 0);
    two(32'h0000_0000, 32'h0101_0000, 32'h9000_0000, 32'h80); run_build("R6 overflow", 0, 0, 0);
    one(32'h1234_0000, 32'h44);        run_build("R6 recovery", 0, 0, 0);
    one(32'h0000_0000, 32'h0100_0000); run_build("R6 exact cap", 0, 0, 0);
    one(32'h0000_0000, 32'h0080_0000); run_build("R6 split cap", 1, 0, 0);
    one(32'h0000_0000, 32'h0081_0000); run_build("R6 split over", 1, 0, 0);
    two(32'h8000_0000, 32'h100, 32'h9000_0000, 32'h1_0000); run_build("R9 flip split", 1, 0, 1);
    two(32'h8000_0000, 32'h100, 32'h9000_0000, 32'h1_0000); run_build("R9 flip alt", 0, 0, 1);

    for (int t = 0; t < 40; t++) begin
      bit sp, al, fl;
      nseg = 1 + int'($urandom_range(0, 3));
      for (int i = 0; i < nseg; i++) begin
        int kind;
        kind = int'($urandom_range(0, 3));
        seg_a[i] = $urandom & 32'hFFFF_FFFC;
        case (kind)
          0: seg_l[i] = $urandom_range(1, 32'h800);
          1: seg_l[i] = $urandom_range(1, 32'h3_0000);
          2: begin seg_l[i] = 32'h1_0000; seg_a[i] = seg_a[i] & 32'hFFFF_0000; end
          default: seg_l[i] = ($urandom_range(0, 1) == 0) ? 32'h0 : 32'h1_0000;
        endcase
      end
      sp = bit'($urandom_range(0, 1));
      al = bit'($urandom_range(0, 1));
      fl = ($urandom_range(0, 4) == 0);
      run_build("R2 random", sp, al, fl);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule